// File: doc/BRIEF.md
# Interval Division Case Selector

This block sits in front of a pair of floating-point dividers that together divide one closed interval by another, A = [a_lo, a_hi] divided by B = [b_lo, b_hi]. It looks only at the sign bits and the two-bit exception fields of the four endpoints. From them it decides which numerator endpoint and which divisor endpoint each divider receives. One divider produces the lower result bound with rounding toward minus infinity. The other produces the upper bound with rounding toward plus infinity.

When the divisor interval touches or contains zero, a quotient alone cannot describe the result. In those cases the selector replaces one or both divider results with a constant: plus infinity, minus infinity or NaN. It also raises a flag when the true result is two disjoint half-lines, (-inf, hi] joined with [lo, +inf).

The selection is purely combinational. A parameter can place one register stage at the outputs.

Each operand word is laid out, from the most significant bit down, as: a 2-bit exception field, a sign bit, an exponent of EXP_W bits, and a fraction of FRAC_W bits.

Top module: `ivdiv_front`

## Requirements
- R1: The exception field of each endpoint is decoded as 00 zero, 01 normal, 10 infinity, 11 NaN. An endpoint is zero exactly when its field is 00, whatever its sign bit. A non-zero endpoint is negative when its sign bit is 1. Infinite endpoints follow their sign.
- R2: When b_lo is positive, the lower and upper dividers get operands according to the class of A:
  - a_lo >= 0: lower a_lo/b_hi, upper a_hi/b_lo.
  - a_lo < 0 <= a_hi: lower a_lo/b_lo, upper a_hi/b_lo.
  - a_hi < 0: lower a_lo/b_lo, upper a_hi/b_hi.
- R3: When b_hi is negative, the dividers get operands according to the class of A:
  - a_lo >= 0: lower a_hi/b_hi, upper a_lo/b_lo.
  - mixed A: lower a_hi/b_hi, upper a_lo/b_hi.
  - a_hi < 0: lower a_hi/b_lo, upper a_lo/b_hi.
- R4: When both b_lo and b_hi are zero and A is not mixed, both override outputs read 11 (NaN, the empty result).
- R5: When A is mixed (a_lo < 0 <= a_hi) and B contains zero, the lower override reads 10 (minus infinity) and the upper override reads 01 (plus infinity).
- R6: When b_lo < 0 and b_hi is zero:
  - a_lo >= 0: lower override 10, upper divider a_lo/b_lo.
  - a_hi < 0: lower divider a_hi/b_lo, upper override 01.
- R7: When b_lo is zero and b_hi > 0:
  - a_lo >= 0: lower divider a_lo/b_hi, upper override 01.
  - a_hi < 0: lower override 10, upper divider a_hi/b_hi.
- R8: When b_lo < 0 < b_hi and A is not mixed, the split flag is 1, the upper divider computes the end of the left piece and the lower divider computes the start of the right piece:
  - a_lo >= 0: upper a_lo/b_lo, lower a_lo/b_hi.
  - a_hi < 0: upper a_hi/b_hi, lower a_hi/b_lo.
  In every other case the split flag is 0.
- R9: The lower divider's rounding output is always 0 (toward minus infinity). The upper divider's rounding output is always 1 (toward plus infinity).
- R10: While an override output is non-zero, that divider's numerator and divisor outputs are all zeros. Override code 00 means the divider result is used.
- R11: With REG_OUT = 1, the outputs follow the inputs one clock later. A synchronous active-high reset clears every operand, override and split output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| a_lo | input | EXP_W+FRAC_W+3 | Lower endpoint of the dividend interval |
| a_hi | input | EXP_W+FRAC_W+3 | Upper endpoint of the dividend interval |
| b_lo | input | EXP_W+FRAC_W+3 | Lower endpoint of the divisor interval |
| b_hi | input | EXP_W+FRAC_W+3 | Upper endpoint of the divisor interval |
| dn_num | output | EXP_W+FRAC_W+3 | Numerator for the round-down divider |
| dn_den | output | EXP_W+FRAC_W+3 | Divisor for the round-down divider |
| dn_rnd | output | 1 | Rounding direction of the lower divider (0) |
| dn_force | output | 2 | Lower bound override: 00 none, 01 +inf, 10 -inf, 11 NaN |
| up_num | output | EXP_W+FRAC_W+3 | Numerator for the round-up divider |
| up_den | output | EXP_W+FRAC_W+3 | Divisor for the round-up divider |
| up_rnd | output | 1 | Rounding direction of the upper divider (1) |
| up_force | output | 2 | Upper bound override, same coding as dn_force |
| split_out | output | 1 | Result is two disjoint half-lines |

## Verification
The interesting overlap is one divider being routed while the other is overridden in the same cycle. This happens for the half-open divisors of R6 and R7. The split case also routes both dividers while raising the flag.

The stimulus table sets a divisor endpoint to zero, sometimes with its sign bit set, next to a non-zero endpoint. Each such vector is judged on the whole output word. The check confirms that the routed lane carries the right endpoint pair, that the overridden lane reads all zeros with the correct constant code, and that the split flag has the expected value in that same cycle.

// File: rtl/ivdiv_pkg.sv
package ivdiv_pkg;

    typedef enum logic [1:0] {
        EXC_ZERO = 2'b00,
        EXC_NORM = 2'b01,
        EXC_INF  = 2'b10,
        EXC_NAN  = 2'b11
    } exc_e;

    typedef enum logic [1:0] {
        FRC_NONE = 2'b00,
        FRC_PINF = 2'b01,
        FRC_NINF = 2'b10,
        FRC_NAN  = 2'b11
    } force_e;

    typedef enum logic {
        RND_DOWN = 1'b0,
        RND_UP   = 1'b1
    } rnd_e;

    // sign class of the dividend interval
    typedef enum logic [1:0] {
        ACL_NONNEG = 2'd0,
        ACL_MIXED  = 2'd1,
        ACL_NEG    = 2'd2
    } acls_e;

    // position of the divisor interval relative to zero
    typedef enum logic [2:0] {
        BCL_POS    = 3'd0,
        BCL_NEG    = 3'd1,
        BCL_ZERO   = 3'd2,
        BCL_LEFT0  = 3'd3,
        BCL_RIGHT0 = 3'd4,
        BCL_SPAN   = 3'd5
    } bcls_e;

    typedef struct packed {
        logic   num_hi;
        logic   den_hi;
        force_e frc;
    } lane_t;

    typedef struct packed {
        lane_t dn;
        lane_t up;
        logic  split;
    } plan_t;

    function automatic logic ep_zero(logic [1:0] exc);
        return exc == EXC_ZERO;
    endfunction

    function automatic logic ep_neg(logic [1:0] exc, logic sgn);
        return (exc != EXC_ZERO) && sgn;
    endfunction

    function automatic lane_t take(logic nh, logic dh);
        lane_t l;
        l.num_hi = nh;
        l.den_hi = dh;
        l.frc    = FRC_NONE;
        return l;
    endfunction

    function automatic lane_t pin(force_e f);
        lane_t l;
        l.num_hi = 1'b0;
        l.den_hi = 1'b0;
        l.frc    = f;
        return l;
    endfunction

    function automatic plan_t decide(acls_e a, bcls_e b);
        plan_t p;
        p.split = 1'b0;
        p.dn    = take(1'b0, 1'b0);
        p.up    = take(1'b0, 1'b0);
        case (b)
            BCL_POS: begin
                case (a)
                    ACL_NONNEG: begin p.dn = take(1'b0, 1'b1); p.up = take(1'b1, 1'b0); end
                    ACL_MIXED:  begin p.dn = take(1'b0, 1'b0); p.up = take(1'b1, 1'b0); end
                    default:    begin p.dn = take(1'b0, 1'b0); p.up = take(1'b1, 1'b1); end
                endcase
            end
            BCL_NEG: begin
                case (a)
                    ACL_NONNEG: begin p.dn = take(1'b1, 1'b1); p.up = take(1'b0, 1'b0); end
                    ACL_MIXED:  begin p.dn = take(1'b1, 1'b1); p.up = take(1'b0, 1'b1); end
                    default:    begin p.dn = take(1'b1, 1'b0); p.up = take(1'b0, 1'b1); end
                endcase
            end
            BCL_ZERO: begin
                if (a == ACL_MIXED) begin
                    p.dn = pin(FRC_NINF); p.up = pin(FRC_PINF);
                end else begin
                    p.dn = pin(FRC_NAN);  p.up = pin(FRC_NAN);
                end
            end
            BCL_LEFT0: begin
                case (a)
                    ACL_NONNEG: begin p.dn = pin(FRC_NINF);     p.up = take(1'b0, 1'b0); end
                    ACL_MIXED:  begin p.dn = pin(FRC_NINF);     p.up = pin(FRC_PINF);    end
                    default:    begin p.dn = take(1'b1, 1'b0);  p.up = pin(FRC_PINF);    end
                endcase
            end
            BCL_RIGHT0: begin
                case (a)
                    ACL_NONNEG: begin p.dn = take(1'b0, 1'b1);  p.up = pin(FRC_PINF);    end
                    ACL_MIXED:  begin p.dn = pin(FRC_NINF);     p.up = pin(FRC_PINF);    end
                    default:    begin p.dn = pin(FRC_NINF);     p.up = take(1'b1, 1'b1); end
                endcase
            end
            default: begin
                case (a)
                    ACL_NONNEG: begin p.dn = take(1'b0, 1'b1); p.up = take(1'b0, 1'b0); p.split = 1'b1; end
                    ACL_MIXED:  begin p.dn = pin(FRC_NINF);    p.up = pin(FRC_PINF);                     end
                    default:    begin p.dn = take(1'b1, 1'b0); p.up = take(1'b1, 1'b1); p.split = 1'b1; end
                endcase
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/ivdiv_classify.sv
module ivdiv_classify
    import ivdiv_pkg::*;
(
    input  logic [3:0][2:0] tags,   // {exc, sign} of a_lo, a_hi, b_lo, b_hi at index 0..3
    output acls_e           a_cls,
    output bcls_e           b_cls
);
    logic [3:0] zro;
    logic [3:0] neg;

    for (genvar g = 0; g < 4; g++) begin : g_ep
        assign zro[g] = ep_zero(tags[g][2:1]);
        assign neg[g] = ep_neg(tags[g][2:1], tags[g][0]);
    end

    always_comb begin
        if (!neg[0])      a_cls = ACL_NONNEG;
        else if (!neg[1]) a_cls = ACL_MIXED;
        else              a_cls = ACL_NEG;
    end

    always_comb begin
        if (!zro[2] && !neg[2])  b_cls = BCL_POS;
        else if (neg[3])         b_cls = BCL_NEG;
        else if (zro[2] && zro[3]) b_cls = BCL_ZERO;
        else if (zro[3])         b_cls = BCL_LEFT0;
        else if (zro[2])         b_cls = BCL_RIGHT0;
        else                     b_cls = BCL_SPAN;
    end
endmodule

// File: rtl/ivdiv_route.sv
module ivdiv_route
    import ivdiv_pkg::*;
#(
    parameter int W = 34
) (
    input  plan_t        plan,
    input  logic [W-1:0] a_lo,
    input  logic [W-1:0] a_hi,
    input  logic [W-1:0] b_lo,
    input  logic [W-1:0] b_hi,
    output logic [W-1:0] dn_num,
    output logic [W-1:0] dn_den,
    output logic [W-1:0] up_num,
    output logic [W-1:0] up_den
);
    lane_t        lane  [2];
    logic [W-1:0] num_w [2];
    logic [W-1:0] den_w [2];

    assign lane[0] = plan.dn;
    assign lane[1] = plan.up;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic held;
        assign held     = lane[g].frc != FRC_NONE;
        assign num_w[g] = held ? '0 : (lane[g].num_hi ? a_hi : a_lo);
        assign den_w[g] = held ? '0 : (lane[g].den_hi ? b_hi : b_lo);
    end

    assign dn_num = num_w[0];
    assign dn_den = den_w[0];
    assign up_num = num_w[1];
    assign up_den = den_w[1];
endmodule

// File: rtl/ivdiv_stage.sv
module ivdiv_stage #(
    parameter int BW      = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] d,
    output logic [BW-1:0] q
);
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= d;
        end
    end else begin : g_wire
        assign q = d;
    end
endmodule

// File: rtl/ivdiv_front.sv
module ivdiv_front
    import ivdiv_pkg::*;
#(
    parameter int  EXP_W   = 8,
    parameter int  FRAC_W  = 23,
    parameter bit  REG_OUT = 1'b1,
    localparam int W       = EXP_W + FRAC_W + 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_lo,
    input  logic [W-1:0] a_hi,
    input  logic [W-1:0] b_lo,
    input  logic [W-1:0] b_hi,
    output logic [W-1:0] dn_num,
    output logic [W-1:0] dn_den,
    output logic         dn_rnd,
    output logic [1:0]   dn_force,
    output logic [W-1:0] up_num,
    output logic [W-1:0] up_den,
    output logic         up_rnd,
    output logic [1:0]   up_force,
    output logic         split_out
);
    localparam int TAG_LSB = W - 3;
    localparam int BW      = 4 * W + 5;

    logic [3:0][2:0] tags;
    acls_e           a_cls;
    bcls_e           b_cls;
    plan_t           plan;
    logic [W-1:0]    c_dn_num, c_dn_den, c_up_num, c_up_den;
    logic [BW-1:0]   bus_d, bus_q;

    assign tags[0] = a_lo[W-1:TAG_LSB];
    assign tags[1] = a_hi[W-1:TAG_LSB];
    assign tags[2] = b_lo[W-1:TAG_LSB];
    assign tags[3] = b_hi[W-1:TAG_LSB];

    ivdiv_classify u_cls (
        .tags  (tags),
        .a_cls (a_cls),
        .b_cls (b_cls)
    );

    assign plan = decide(a_cls, b_cls);

    ivdiv_route #(.W(W)) u_route (
        .plan   (plan),
        .a_lo   (a_lo),
        .a_hi   (a_hi),
        .b_lo   (b_lo),
        .b_hi   (b_hi),
        .dn_num (c_dn_num),
        .dn_den (c_dn_den),
        .up_num (c_up_num),
        .up_den (c_up_den)
    );

    assign bus_d = {c_dn_num, c_dn_den, c_up_num, c_up_den,
                    plan.dn.frc, plan.up.frc, plan.split};

    ivdiv_stage #(.BW(BW), .REG_OUT(REG_OUT)) u_stage (
        .clk (clk),
        .rst (rst),
        .d   (bus_d),
        .q   (bus_q)
    );

    assign {dn_num, dn_den, up_num, up_den, dn_force, up_force, split_out} = bus_q;
    assign dn_rnd = RND_DOWN;
    assign up_rnd = RND_UP;
endmodule

// File: rtl/ivdiv_front_chk.sv
module ivdiv_front_chk #(
    parameter int W       = 34,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   t_a_lo,
    input logic [2:0]   t_a_hi,
    input logic [2:0]   t_b_lo,
    input logic [2:0]   t_b_hi,
    input logic [W-1:0] dn_num,
    input logic [W-1:0] dn_den,
    input logic [1:0]   dn_force,
    input logic [1:0]   up_force,
    input logic         split_out
);
    logic       vld;
    logic [2:0] s_a_lo, s_a_hi, s_b_lo, s_b_hi;

    if (REG_OUT) begin : g_dly
        always_ff @(posedge clk) begin
            vld    <= !rst;
            s_a_lo <= t_a_lo;
            s_a_hi <= t_a_hi;
            s_b_lo <= t_b_lo;
            s_b_hi <= t_b_hi;
        end

        // R11: while no input has yet been captured since reset, outputs stay cleared
        a_r11_reset_clear: assert property (@(posedge clk) disable iff (rst)
            !vld |-> (split_out == 1'b0 && dn_force == 2'b00 && up_force == 2'b00 && dn_num == '0));
    end else begin : g_now
        assign vld    = 1'b1;
        assign s_a_lo = t_a_lo;
        assign s_a_hi = t_a_hi;
        assign s_b_lo = t_b_lo;
        assign s_b_hi = t_b_hi;
    end

    logic bl_zero, bh_zero, bl_neg, bh_pos, a_mixed, b_has0;
    assign bl_zero = s_b_lo[2:1] == 2'b00;
    assign bh_zero = s_b_hi[2:1] == 2'b00;
    assign bl_neg  = !bl_zero && s_b_lo[0];
    assign bh_pos  = !bh_zero && !s_b_hi[0];
    assign a_mixed = (s_a_lo[2:1] != 2'b00) && s_a_lo[0] &&
                     ((s_a_hi[2:1] == 2'b00) || !s_a_hi[0]);
    assign b_has0  = (bl_zero || bl_neg) && (bh_zero || bh_pos);

    a_r8_split_needs_span: assert property (@(posedge clk) disable iff (rst)
        (vld && split_out) |-> (bl_neg && bh_pos && !a_mixed));

    a_r10_forced_lane_zero: assert property (@(posedge clk) disable iff (rst)
        (vld && dn_force != 2'b00) |-> (dn_num == '0 && dn_den == '0));

    a_r4_empty_result: assert property (@(posedge clk) disable iff (rst)
        (vld && bl_zero && bh_zero && !a_mixed) |-> (dn_force == 2'b11 && up_force == 2'b11));

    a_r5_whole_line: assert property (@(posedge clk) disable iff (rst)
        (vld && a_mixed && b_has0) |-> (dn_force == 2'b10 && up_force == 2'b01 && !split_out));
endmodule

bind ivdiv_front ivdiv_front_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .t_a_lo    (a_lo[W-1:W-3]),
    .t_a_hi    (a_hi[W-1:W-3]),
    .t_b_lo    (b_lo[W-1:W-3]),
    .t_b_hi    (b_hi[W-1:W-3]),
    .dn_num    (dn_num),
    .dn_den    (dn_den),
    .dn_force  (dn_force),
    .up_force  (up_force),
    .split_out (split_out)
);

// File: tb/ivdiv_front_bench.sv
module ivdiv_front_bench;
    localparam int EXP_W = 8;
    localparam int FRAC_W = 23;
    localparam int W = EXP_W + FRAC_W + 3;
    localparam int BW = 4 * W + 5;

    // endpoint kinds: 0 zero, 1 positive, 2 negative, 3 +inf, 4 -inf, 5 zero with sign bit
    typedef struct packed {
        logic [2:0] ka1, ka2, kb1, kb2;
        logic       dnn, dnd, upn, upd;   // 1 selects the hi endpoint
        logic [1:0] dnf, upf;             // 00 none 01 +inf 10 -inf 11 NaN
        logic       spl;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{3'd1,3'd1,3'd1,3'd1, 1'b0,1'b1,1'b1,1'b0, 2'd0,2'd0, 1'b0, 4'd2},  // R2 nonneg A
        '{3'd2,3'd1,3'd1,3'd1, 1'b0,1'b0,1'b1,1'b0, 2'd0,2'd0, 1'b0, 4'd2},  // R2 mixed A
        '{3'd2,3'd2,3'd1,3'd1, 1'b0,1'b0,1'b1,1'b1, 2'd0,2'd0, 1'b0, 4'd2},  // R2 negative A
        '{3'd1,3'd1,3'd2,3'd2, 1'b1,1'b1,1'b0,1'b0, 2'd0,2'd0, 1'b0, 4'd3},  // R3
        '{3'd2,3'd1,3'd2,3'd2, 1'b1,1'b1,1'b0,1'b1, 2'd0,2'd0, 1'b0, 4'd3},  // R3
        '{3'd2,3'd2,3'd2,3'd2, 1'b1,1'b0,1'b0,1'b1, 2'd0,2'd0, 1'b0, 4'd3},  // R3
        '{3'd0,3'd1,3'd1,3'd1, 1'b0,1'b1,1'b1,1'b0, 2'd0,2'd0, 1'b0, 4'd1},  // R1 zero a_lo is nonneg
        '{3'd1,3'd1,3'd0,3'd0, 1'b0,1'b0,1'b0,1'b0, 2'd3,2'd3, 1'b0, 4'd4},  // R4
        '{3'd2,3'd2,3'd0,3'd0, 1'b0,1'b0,1'b0,1'b0, 2'd3,2'd3, 1'b0, 4'd4},  // R4
        '{3'd2,3'd1,3'd0,3'd0, 1'b0,1'b0,1'b0,1'b0, 2'd2,2'd1, 1'b0, 4'd5},  // R5
        '{3'd1,3'd1,3'd2,3'd0, 1'b0,1'b0,1'b0,1'b0, 2'd2,2'd0, 1'b0, 4'd6},  // R6
        '{3'd2,3'd2,3'd2,3'd0, 1'b1,1'b0,1'b0,1'b0, 2'd0,2'd1, 1'b0, 4'd6},  // R6
        '{3'd1,3'd1,3'd0,3'd1, 1'b0,1'b1,1'b0,1'b0, 2'd0,2'd1, 1'b0, 4'd7},  // R7
        '{3'd2,3'd2,3'd0,3'd1, 1'b0,1'b0,1'b1,1'b1, 2'd2,2'd0, 1'b0, 4'd7},  // R7
        '{3'd1,3'd1,3'd2,3'd1, 1'b0,1'b1,1'b0,1'b0, 2'd0,2'd0, 1'b1, 4'd8},  // R8
        '{3'd2,3'd2,3'd2,3'd1, 1'b1,1'b0,1'b1,1'b1, 2'd0,2'd0, 1'b1, 4'd8},  // R8
        '{3'd2,3'd1,3'd2,3'd1, 1'b0,1'b0,1'b0,1'b0, 2'd2,2'd1, 1'b0, 4'd5},  // R5
        '{3'd2,3'd1,3'd2,3'd0, 1'b0,1'b0,1'b0,1'b0, 2'd2,2'd1, 1'b0, 4'd5},  // R5
        '{3'd2,3'd1,3'd0,3'd1, 1'b0,1'b0,1'b0,1'b0, 2'd2,2'd1, 1'b0, 4'd5},  // R5
        '{3'd1,3'd1,3'd5,3'd1, 1'b0,1'b1,1'b0,1'b0, 2'd0,2'd1, 1'b0, 4'd1},  // R1 signed zero b_lo
        '{3'd1,3'd3,3'd1,3'd1, 1'b0,1'b1,1'b1,1'b0, 2'd0,2'd0, 1'b0, 4'd1},  // R1 infinite a_hi
        '{3'd0,3'd0,3'd2,3'd2, 1'b1,1'b1,1'b0,1'b0, 2'd0,2'd0, 1'b0, 4'd3},  // R3 A=[0,0]
        '{3'd4,3'd2,3'd1,3'd3, 1'b0,1'b0,1'b1,1'b1, 2'd0,2'd0, 1'b0, 4'd2},  // R2 infinite ends
        '{3'd2,3'd5,3'd0,3'd0, 1'b0,1'b0,1'b0,1'b0, 2'd2,2'd1, 1'b0, 4'd1}   // R1 a_hi=-0 gives mixed A
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a_lo = '0, a_hi = '0, b_lo = '0, b_hi = '0;
    logic [W-1:0] dn_num, dn_den, up_num, up_den;
    logic         dn_rnd, up_rnd, split_out;
    logic [1:0]   dn_force, up_force;
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ivdiv_front #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .REG_OUT(1'b1)) u_ivdiv_front (
        .clk(clk), .rst(rst),
        .a_lo(a_lo), .a_hi(a_hi), .b_lo(b_lo), .b_hi(b_hi),
        .dn_num(dn_num), .dn_den(dn_den), .dn_rnd(dn_rnd), .dn_force(dn_force),
        .up_num(up_num), .up_den(up_den), .up_rnd(up_rnd), .up_force(up_force),
        .split_out(split_out)
    );

    function automatic logic [W-1:0] mkv(logic [2:0] kind, int idx);
        logic [EXP_W-1:0]  e = EXP_W'(8'h70 + idx);
        logic [FRAC_W-1:0] f = FRAC_W'(idx * 4099 + 1);
        case (kind)
            3'd0:    return {2'b00, 1'b0, {EXP_W{1'b0}}, {FRAC_W{1'b0}}};
            3'd1:    return {2'b01, 1'b0, e, f};
            3'd2:    return {2'b01, 1'b1, e, f};
            3'd3:    return {2'b10, 1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            3'd4:    return {2'b10, 1'b1, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            default: return {2'b00, 1'b1, {EXP_W{1'b0}}, {FRAC_W{1'b0}}};
        endcase
    endfunction

    function automatic logic [BW-1:0] outs();
        return {dn_num, dn_den, up_num, up_den, dn_force, up_force, split_out};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        a_lo = mkv(v.ka1, 1);
        a_hi = mkv(v.ka2, 2);
        b_lo = mkv(v.kb1, 3);
        b_hi = mkv(v.kb2, 4);
    endtask

    function automatic logic [BW-1:0] expect_of(vec_t v);
        logic [W-1:0] al = mkv(v.ka1, 1), ah = mkv(v.ka2, 2);
        logic [W-1:0] bl = mkv(v.kb1, 3), bh = mkv(v.kb2, 4);
        logic [W-1:0] dnn = (v.dnf != 2'd0) ? '0 : (v.dnn ? ah : al);
        logic [W-1:0] dnd = (v.dnf != 2'd0) ? '0 : (v.dnd ? bh : bl);
        logic [W-1:0] upn = (v.upf != 2'd0) ? '0 : (v.upn ? ah : al);
        logic [W-1:0] upd = (v.upf != 2'd0) ? '0 : (v.upd ? bh : bl);
        return {dnn, dnd, upn, upd, v.dnf, v.upf, v.spl};
    endfunction

    initial begin
        // R11: reset clears outputs even with live inputs
        apply(VEC[0]);
        repeat (2) @(negedge clk);
        chk(outs() == '0, "R11", "outputs under reset", outs(), '0);
        rst = 1'b0;

        // table walk: R1..R8 and R10 on the whole output word, R9 on rounding pins
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            @(negedge clk);
            chk(outs() == expect_of(VEC[i]), $sformatf("R%0d", VEC[i].req),
                $sformatf("vector %0d", i), outs(), expect_of(VEC[i]));
            chk(dn_rnd == 1'b0 && up_rnd == 1'b1, "R9", "rounding pins",
                BW'({dn_rnd, up_rnd}), BW'(2'b01));
        end

        // R11: one-cycle latency, output holds until the next edge
        @(negedge clk);
        apply(VEC[14]);
        #2;
        chk(outs() == expect_of(VEC[NV-1]), "R11", "held before edge",
            outs(), expect_of(VEC[NV-1]));
        @(negedge clk);
        chk(outs() == expect_of(VEC[14]), "R11", "updated after edge",
            outs(), expect_of(VEC[14]));

        // R8: leaving the span case drops the split flag
        apply(VEC[12]);
        @(negedge clk);
        chk(split_out == 1'b0, "R8", "split cleared", BW'(split_out), '0);

        // R11: reset mid-run clears split and overrides
        apply(VEC[15]);
        rst = 1'b1;
        @(negedge clk);
        chk(outs() == '0, "R11", "mid-run reset", outs(), '0);
        rst = 1'b0;
        @(negedge clk);
        chk(outs() == expect_of(VEC[15]), "R8", "after reset release",
            outs(), expect_of(VEC[15]));
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule